// File: doc/BRIEF.md
# Byte-wide nonvolatile store access controller

This block connects a small CPU register window to a byte-addressed nonvolatile data array. The array is modelled as a plain register array whose writes take effect only after a programmable programming interval. Software loads an address register and a data register, then issues a read or write command through a control register. Each command moves exactly one byte. While a command is being taken up, the controller holds the CPU with a halt output. A read stalls the CPU for four cycles, and a write stalls it for two.

A write only starts after a two-step arming procedure. Software first sets an arm bit, which opens a short acceptance window. The write command must then arrive while that window is open. After the two halt cycles, programming continues in the background. A busy bit in the control register stays set until the new byte has been committed, so software can poll it before issuing the next access. Reset clears the control state but leaves the stored bytes alone.

Top module: `nvbyte_ctrl`

## Requirements
- R1: The array holds DEPTH bytes (DEPTH is 128, 256 or 512), and the address register is AW = log2(DEPTH) bits wide. Register select 0 reaches address bits 7:0 and select 3 reaches address bits 15:8. Bits at or above AW are not stored and read back as 0 (with DEPTH 128, writing 0xFF to select 0 reads back as 0x7F).
- R2: Writing the control register (select 2) with bit 0 set starts a read when the controller is idle. The cpu_halt output is high for exactly 4 cycles, starting with the cycle after the write. When cpu_halt falls, the data register (select 1) holds the addressed array byte.
- R3: An accepted write command (control bit 1) raises cpu_halt for exactly 2 cycles. At the end of the programming interval, the data register value is stored at the addressed location.
- R4: Control bit 3 (busy) reads 1 for exactly 2 + PROG_CYCLES cycles, starting with the cycle after the accepted write command. It then reads 0.
- R5: Writing control bit 2 arms writes. Control bit 2 then reads 1 for ARM_WINDOW (4) cycles and clears itself. A write command issued while not armed has no effect: no halt, no busy, and the array is unchanged.
- R6: A write command issued on the last armed cycle is accepted. A write command issued after the window has expired is ignored.
- R7: While a command is in progress (halt or busy set), read and write commands are ignored, and writes to the address and data registers have no effect.
- R8: Control bits 0 and 1 always read back as 0. An accepted write command clears the arm bit at once.
- R9: If control bits 0 and 1 are written as 1 in the same cycle, only the read is performed. The array is unchanged and busy stays 0.
- R10: Reset (rst_n low) clears cpu_halt, busy, the arm bit, the address register and the data register. It aborts any programming in progress and leaves the array contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 2 | Register select: 0 address low, 1 data, 2 control, 3 address high |
| bus_we | input | 1 | Register write strobe for the selected register |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Read value of the selected register |
| cpu_halt | output | 1 | Stall request to the CPU |

## Verification
The hardest states to reach are the edges of the arming window. A write command must land on exactly the last armed cycle and also on the first expired cycle. The table-driven part issues each write command after 0 to 3 idle cycles following the arm. A directed test then waits one cycle longer, and its write must be rejected. A second hard case is reset arriving in the middle of programming. It is reached by asserting reset a few cycles into a busy interval and then reading back the old byte.

// File: rtl/nvbyte_pkg.sv
package nvbyte_pkg;

  // Fixed CPU stall lengths per access type
  localparam int unsigned RD_STALL = 4;
  localparam int unsigned WR_STALL = 2;

  // Register select codes
  localparam logic [1:0] SEL_ADDR_LO = 2'd0;
  localparam logic [1:0] SEL_DATA    = 2'd1;
  localparam logic [1:0] SEL_CTRL    = 2'd2;
  localparam logic [1:0] SEL_ADDR_HI = 2'd3;

  // Control register bit positions
  localparam int unsigned CB_RD   = 0;
  localparam int unsigned CB_WR   = 1;
  localparam int unsigned CB_ARM  = 2;
  localparam int unsigned CB_BUSY = 3;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_READ  = 2'd1,
    SQ_WHALT = 2'd2,
    SQ_PROG  = 2'd3
  } seq_state_e;

endpackage

// File: rtl/nvbyte_rstsync.sv
module nvbyte_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [1:0] sync_q;

  // Assert asynchronously, release after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_ns = sync_q[1];
endmodule

// File: rtl/nvbyte_arm.sv
module nvbyte_arm #(
  parameter int unsigned WINDOW = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_set,
  input  logic consume,
  output logic armed
);
  localparam int unsigned WW = $clog2(WINDOW + 1);

  logic [WW-1:0] win_q, win_d;
  logic          win_en;

  always_comb begin
    win_d = win_q;
    if (consume)           win_d = '0;
    else if (arm_set)      win_d = WW'(WINDOW);
    else if (win_q != '0)  win_d = win_q - 1'b1;
  end

  assign win_en = consume || arm_set || (win_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      win_q <= '0;
    else if (win_en) win_q <= win_d;
  end

  assign armed = (win_q != '0);

  // R5
  arm_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_set && !consume) |=> armed);

  // R8
  arm_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    consume |=> !armed);
endmodule

// File: rtl/nvbyte_seq.sv
module nvbyte_seq
  import nvbyte_pkg::*;
#(
  parameter int unsigned PROG_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_start,
  input  logic wr_start,
  output logic idle,
  output logic halt,
  output logic busy,
  output logic rd_done,
  output logic commit
);
  localparam int unsigned CMAX = (PROG_CYCLES > RD_STALL) ? PROG_CYCLES : RD_STALL;
  localparam int unsigned CW   = $clog2(CMAX + 1);

  seq_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          seq_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    rd_done = 1'b0;
    commit  = 1'b0;
    case (state_q)
      SQ_IDLE: begin
        if (rd_start) begin
          state_d = SQ_READ;
          cnt_d   = CW'(RD_STALL - 1);
        end else if (wr_start) begin
          state_d = SQ_WHALT;
          cnt_d   = CW'(WR_STALL - 1);
        end
      end
      SQ_READ: begin
        if (cnt_q == '0) begin
          state_d = SQ_IDLE;
          rd_done = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      SQ_WHALT: begin
        if (cnt_q == '0) begin
          state_d = SQ_PROG;
          cnt_d   = CW'(PROG_CYCLES - 1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      SQ_PROG: begin
        if (cnt_q == '0) begin
          state_d = SQ_IDLE;
          commit  = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  assign seq_en = (state_q != SQ_IDLE) || rd_start || wr_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      cnt_q   <= '0;
    end else if (seq_en) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign idle = (state_q == SQ_IDLE);
  assign halt = (state_q == SQ_READ) || (state_q == SQ_WHALT);
  assign busy = (state_q == SQ_WHALT) || (state_q == SQ_PROG);

  // R2
  rd_stall_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && rd_start) |=> halt ##1 halt ##1 halt ##1 halt ##1 !halt);

  // R3
  wr_stall_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && wr_start && !rd_start) |=> halt ##1 halt ##1 (!halt && busy));

  // R3
  commit_in_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (busy && !halt));

  // R9
  one_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_start, wr_start}));
endmodule

// File: rtl/nvbyte_array.sv
module nvbyte_array #(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  // Storage cells carry no reset: contents survive a controller reset
  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[addr] <= wdata;
  end

  assign rdata = cells[addr];
endmodule

// File: rtl/nvbyte_ctrl.sv
module nvbyte_ctrl
  import nvbyte_pkg::*;
#(
  parameter int unsigned DEPTH       = 128,
  parameter int unsigned PROG_CYCLES = 8,
  parameter int unsigned ARM_WINDOW  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] bus_sel,
  input  logic       bus_we,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       cpu_halt
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic          rst_ns;
  logic [AW-1:0] addr_q, addr_d;
  logic [7:0]    data_q, data_d;
  logic          addr_en, data_en;
  logic [15:0]   addr_wide, addr_new;
  logic          ctrl_wr, rd_acc, wr_acc, arm_set;
  logic          seq_idle, seq_halt, seq_busy, rd_done, commit, armed;
  logic [7:0]    arr_rdata;

  nvbyte_rstsync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ns (rst_ns)
  );

  // Command decode: read wins over write, both need an idle sequencer
  assign ctrl_wr = bus_we && (bus_sel == SEL_CTRL);
  assign rd_acc  = ctrl_wr && bus_wdata[CB_RD] && seq_idle;
  assign wr_acc  = ctrl_wr && bus_wdata[CB_WR] && !bus_wdata[CB_RD] && seq_idle && armed;
  assign arm_set = ctrl_wr && bus_wdata[CB_ARM];

  nvbyte_arm #(.WINDOW(ARM_WINDOW)) u_arm (
    .clk     (clk),
    .rst_n   (rst_ns),
    .arm_set (arm_set),
    .consume (wr_acc),
    .armed   (armed)
  );

  nvbyte_seq #(.PROG_CYCLES(PROG_CYCLES)) u_seq (
    .clk      (clk),
    .rst_n    (rst_ns),
    .rd_start (rd_acc),
    .wr_start (wr_acc),
    .idle     (seq_idle),
    .halt     (seq_halt),
    .busy     (seq_busy),
    .rd_done  (rd_done),
    .commit   (commit)
  );

  nvbyte_array #(.DEPTH(DEPTH), .AW(AW)) u_arr (
    .clk   (clk),
    .we    (commit),
    .addr  (addr_q),
    .wdata (data_q),
    .rdata (arr_rdata)
  );

  // Address register: two byte lanes, truncated to AW bits
  assign addr_wide = 16'(addr_q);

  always_comb begin
    addr_new = addr_wide;
    if (bus_sel == SEL_ADDR_LO) addr_new[7:0]  = bus_wdata;
    else                        addr_new[15:8] = bus_wdata;
    addr_d = AW'(addr_new);
  end

  assign addr_en = bus_we && seq_idle &&
                   ((bus_sel == SEL_ADDR_LO) || (bus_sel == SEL_ADDR_HI));

  // Data register: loaded by read completion or by CPU while idle
  always_comb begin
    data_d = data_q;
    if (rd_done) data_d = arr_rdata;
    else         data_d = bus_wdata;
  end

  assign data_en = rd_done || (bus_we && seq_idle && (bus_sel == SEL_DATA));

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)      addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)      data_q <= '0;
    else if (data_en) data_q <= data_d;
  end

  always_comb begin
    case (bus_sel)
      SEL_ADDR_LO: bus_rdata = addr_wide[7:0];
      SEL_DATA:    bus_rdata = data_q;
      SEL_CTRL: begin
        bus_rdata          = '0;
        bus_rdata[CB_ARM]  = armed;
        bus_rdata[CB_BUSY] = seq_busy;
      end
      default:     bus_rdata = addr_wide[15:8];
    endcase
  end

  assign cpu_halt = seq_halt;

  // R7
  lock_addr_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (!seq_idle && bus_we && (bus_sel != SEL_CTRL) && (bus_sel != SEL_DATA)) |=> $stable(addr_q));

  // R7
  lock_data_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (seq_busy && bus_we && (bus_sel == SEL_DATA)) |=> $stable(data_q));

  // R5
  no_unarmed_write_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (seq_idle && !armed) |=> !seq_busy);

  // R2
  read_loads_data_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    rd_done |=> (data_q == $past(arr_rdata)));
endmodule

// File: tb/nvbyte_ctrl_tb.sv
`timescale 1ns/1ps
module nvbyte_ctrl_tb;
  localparam int PROG = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_sel = 2'd2;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       cpu_halt;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  nvbyte_ctrl #(.DEPTH(128), .PROG_CYCLES(PROG), .ARM_WINDOW(4)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cpu_halt  (cpu_halt)
  );

  // op (1 write / 0 read-and-compare), address, data
  localparam logic [16:0] VEC [10] = '{
    17'h1_00_A5, 17'h1_7F_3C, 17'h1_10_00, 17'h0_00_A5, 17'h0_7F_3C,
    17'h1_10_FF, 17'h0_10_FF, 17'h1_00_5A, 17'h0_00_5A, 17'h0_10_FF
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic bwr(input logic [1:0] s, input logic [7:0] d);
    bus_sel = s; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic brd(input logic [1:0] s, output logic [7:0] d);
    bus_sel = s;
    #1;
    d = bus_rdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // Count halt and busy cycles from the negedge after an accepted write
  task automatic watch_busy(output int h, output int b);
    logic [7:0] v;
    h = 0; b = 0;
    forever begin
      brd(2'd2, v);
      if (!v[3] || b > 100) break;
      b++;
      if (cpu_halt) h++;
      @(negedge clk);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d, input int gap);
    logic [7:0] v;
    int h, b;
    bwr(2'd0, a);
    bwr(2'd1, d);
    bwr(2'd2, 8'h04);
    brd(2'd2, v);
    chk("R5 arm bit set", v, 8'h04);
    repeat (gap) @(negedge clk);
    bwr(2'd2, 8'h02);
    brd(2'd2, v);
    chk("R8 strobe reads 0, arm consumed", v, 8'h08);
    watch_busy(h, b);
    chk("R3 write halt length", h, 2);
    chk("R4 busy length", b, 2 + PROG);
    @(negedge clk);
  endtask

  task automatic do_read(input logic [7:0] a, output logic [7:0] d, output int h);
    bwr(2'd0, a);
    bwr(2'd2, 8'h01);
    h = 0;
    while (cpu_halt && h < 20) begin
      h++;
      @(negedge clk);
    end
    brd(2'd1, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [7:0] v;
    int h, b;
    @(negedge clk);
    do_reset();

    // R10 reset state
    chk("R10 halt after reset", cpu_halt, 0);
    brd(2'd2, v); chk("R10 ctrl after reset", v, 8'h00);
    brd(2'd0, v); chk("R10 addr after reset", v, 8'h00);
    brd(2'd1, v); chk("R10 data after reset", v, 8'h00);

    // Table walk: R2 R3 R4
    for (int i = 0; i < 10; i++) begin
      if (VEC[i][16]) begin
        do_write(VEC[i][15:8], VEC[i][7:0], i % 4);
      end else begin
        do_read(VEC[i][15:8], v, h);
        chk("R2 read halt length", h, 4);
        chk("R2 read data", v, VEC[i][7:0]);
      end
    end

    // R1 address truncation
    bwr(2'd0, 8'hFF); brd(2'd0, v); chk("R1 addr low truncated", v, 8'h7F);
    bwr(2'd3, 8'hFF); brd(2'd3, v); chk("R1 addr high unused", v, 8'h00);

    // R5 lone write strobe without arm
    bwr(2'd0, 8'h00);
    bwr(2'd1, 8'h11);
    bwr(2'd2, 8'h02);
    chk("R5 no halt when unarmed", cpu_halt, 0);
    brd(2'd2, v); chk("R5 no busy when unarmed", v, 8'h00);
    do_read(8'h00, v, h);
    chk("R5 array unchanged", v, 8'h5A);

    // R6 strobe after window expiry
    bwr(2'd1, 8'h22);
    bwr(2'd2, 8'h04);
    repeat (4) @(negedge clk);
    brd(2'd2, v); chk("R5 arm bit self-clears", v, 8'h00);
    bwr(2'd2, 8'h02);
    chk("R6 expired strobe no halt", cpu_halt, 0);
    do_read(8'h00, v, h);
    chk("R6 array unchanged", v, 8'h5A);

    // R7 register and strobe lockout while busy
    bwr(2'd0, 8'h30);
    bwr(2'd1, 8'h77);
    bwr(2'd2, 8'h04);
    bwr(2'd2, 8'h02);
    bwr(2'd0, 8'h40);
    bwr(2'd1, 8'h99);
    bwr(2'd2, 8'h01);
    watch_busy(h, b);
    chk("R7 busy not extended", b, 2 + PROG - 3);
    chk("R7 no halt after busy", cpu_halt, 0);
    brd(2'd0, v); chk("R7 addr locked", v, 8'h30);
    brd(2'd1, v); chk("R7 data locked", v, 8'h77);
    do_read(8'h30, v, h);
    chk("R7 write committed", v, 8'h77);

    // R9 simultaneous strobes: read only
    bwr(2'd1, 8'hEE);
    bwr(2'd2, 8'h04);
    bwr(2'd2, 8'h03);
    h = 0;
    while (cpu_halt && h < 20) begin
      h++;
      @(negedge clk);
    end
    chk("R9 read halt length", h, 4);
    brd(2'd1, v); chk("R9 read data", v, 8'h77);
    brd(2'd2, v); chk("R9 no busy", v[3], 0);
    do_read(8'h30, v, h);
    chk("R9 array unchanged", v, 8'h77);

    // R10 reset during programming
    bwr(2'd0, 8'h30);
    bwr(2'd1, 8'h12);
    bwr(2'd2, 8'h04);
    bwr(2'd2, 8'h02);
    repeat (3) @(negedge clk);
    do_reset();
    chk("R10 halt cleared", cpu_halt, 0);
    brd(2'd2, v); chk("R10 ctrl cleared", v, 8'h00);
    do_read(8'h30, v, h);
    chk("R10 aborted write keeps old byte", v, 8'h77);
    do_read(8'h7F, v, h);
    chk("R10 contents retained", v, 8'h3C);

    summary();
  end
endmodule